// File: doc/BRIEF.md
# Indirect PHY register access bridge

The bridge gives a host a window onto a byte-wide PHY register space of 256 entries through just two host-visible registers. One of them is a data register. The other is a command register, which holds the PHY register index, a direction flag and a busy flag. Software fills the data register first and then writes the command word. That command write launches a single PHY transaction. Software then polls the busy flag until it drops. After a read, the PHY byte is found in the low byte of the data register.

On the PHY side, the bridge drives a level request that stays asserted for the whole transaction, together with the index, the direction and the write byte. It waits for a one-cycle acknowledge. A behavioural PHY register file with a configurable response latency is included so that the bridge can be exercised on its own.

Top module: `phybr_top`

## Requirements
- R1: After reset, the command register (host offset 0x300) and the data register (host offset 0x304) both read 0, and the busy flag is clear.
- R2: While idle, a host write to offset 0x304 stores the full 16-bit word, and a read of 0x304 returns it unchanged.
- R3: A command write to 0x300 with bit 8 set writes the low byte of the data register into the PHY register whose index is given by bits 7:0 of the command word.
- R4: A command write to 0x300 with bit 8 clear reads the indexed PHY register. Once busy drops, the byte is in bits 7:0 of the data register and bits 15:8 read 0.
- R5: Bit 9 of the command register reads 1 from the cycle after an accepted command write until the PHY acknowledge, then reads 0. With the behavioural PHY it stays at 1 for exactly LATENCY+2 clock cycles.
- R6: A command write while busy reads 1 is ignored: the index, the direction and the running transaction are unchanged, and no second PHY access takes place.
- R7: A write to the data register while busy reads 1 is ignored.
- R8: Index, direction and write byte on the PHY port stay stable while the request is held. The request drops on the cycle after the acknowledge.
- R9: When idle, bits 7:0 and bit 8 of the command register read back the index and the direction of the last accepted command.
- R10: The behavioural PHY resets each register i to i XOR 0xA5. It pulses its acknowledge for one cycle, LATENCY cycles after it accepts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_we | input | 1 | Host write strobe |
| hb_addr | input | 12 | Host register offset |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data, combinational on hb_addr |
| phy_req | output | 1 | PHY transaction request, held until acknowledge |
| phy_wr | output | 1 | 1 for a PHY write, 0 for a PHY read |
| phy_idx | output | 8 | PHY register index |
| phy_wdata | output | 8 | PHY write byte |
| phy_ack | input | 1 | PHY completion pulse |
| phy_rdata | input | 8 | PHY read byte, valid with phy_ack |

## Verification
Every one of the 256 indices is read straight after reset. Before each of these reads the data register is preloaded with all ones, so the reset pattern confirms that index decode is correct and that the upper data bits are cleared. Every index is then written with an arithmetic pattern that differs from the reset pattern and read back, which separates writes that took effect from writes that were dropped or misrouted. Overlapping command and data writes are injected during a busy transaction. The bench then checks the command readback, the data register and the neighbouring PHY registers, so that an ignored access can be told apart from one that leaked through. The busy period is counted cycle by cycle against LATENCY+2.

// File: rtl/phybr_pkg.sv
package phybr_pkg;

    localparam int IDX_W    = 8;
    localparam int BYTE_W   = 8;
    localparam int HOST_DW  = 16;
    localparam int HOST_AW  = 12;
    localparam int WR_BIT   = IDX_W;
    localparam int BUSY_BIT = IDX_W + 1;

    localparam logic [HOST_AW-1:0] CMD_OFS  = 12'h300;
    localparam logic [HOST_AW-1:0] DATA_OFS = 12'h304;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_DATA
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        logic [IDX_W-1:0] idx;
    } phy_cmd_t;

    function automatic reg_sel_e decode_addr(input logic [HOST_AW-1:0] a);
        if (a == CMD_OFS)       return SEL_CMD;
        else if (a == DATA_OFS) return SEL_DATA;
        else                    return SEL_NONE;
    endfunction

    function automatic phy_cmd_t unpack_cmd(input logic [HOST_DW-1:0] w);
        phy_cmd_t c;
        c.wr  = w[WR_BIT];
        c.idx = w[IDX_W-1:0];
        return c;
    endfunction

    function automatic logic [HOST_DW-1:0] pack_status(input phy_cmd_t c, input logic busy);
        logic [HOST_DW-1:0] w;
        w              = '0;
        w[IDX_W-1:0]   = c.idx;
        w[WR_BIT]      = c.wr;
        w[BUSY_BIT]    = busy;
        return w;
    endfunction

endpackage

// File: rtl/phybr_phymem.sv
module phybr_phymem
    import phybr_pkg::*;
#(
    parameter int               LATENCY = 3,
    parameter logic [BYTE_W-1:0] RST_PAT = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic              ack,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int CW    = $clog2(LATENCY + 1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              active;
    logic [CW-1:0]     cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            ack    <= 1'b0;
            rdata  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= BYTE_W'(i) ^ RST_PAT;
            end
        end else begin
            ack <= 1'b0;
            if (!active && req && !ack) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active) begin
                if (cnt == CW'(LATENCY - 1)) begin
                    active <= 1'b0;
                    ack    <= 1'b1;
                    if (wr) mem[idx] <= wdata;
                    else    rdata    <= mem[idx];
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/phybr_hostregs.sv
module phybr_hostregs
    import phybr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hb_we,
    input  logic [HOST_AW-1:0] hb_addr,
    input  logic [HOST_DW-1:0] hb_wdata,
    output logic [HOST_DW-1:0] hb_rdata,
    input  logic               busy,
    input  phy_cmd_t           cur_cmd,
    input  logic               cap_en,
    input  logic [BYTE_W-1:0]  cap_byte,
    output logic               cmd_stb,
    output phy_cmd_t           cmd_new,
    output logic [HOST_DW-1:0] data_q
);
    reg_sel_e sel;

    always_comb begin
        sel     = decode_addr(hb_addr);
        cmd_stb = hb_we && (sel == SEL_CMD);
        cmd_new = unpack_cmd(hb_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (cap_en) begin
            data_q <= HOST_DW'(cap_byte);
        end else if (hb_we && (sel == SEL_DATA) && !busy) begin
            data_q <= hb_wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CMD:  hb_rdata = pack_status(cur_cmd, busy);
            SEL_DATA: hb_rdata = data_q;
            default:  hb_rdata = '0;
        endcase
    end
endmodule

// File: rtl/phybr_ctrl.sv
module phybr_ctrl
    import phybr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_stb,
    input  phy_cmd_t          cmd_new,
    output logic              busy,
    output phy_cmd_t          cur_cmd,
    output logic              phy_req,
    output logic              phy_wr,
    output logic [IDX_W-1:0]  phy_idx,
    input  logic              phy_ack,
    input  logic [BYTE_W-1:0] phy_rdata,
    output logic              cap_en,
    output logic [BYTE_W-1:0] cap_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cur_cmd <= '0;
        end else if (busy) begin
            if (phy_ack) busy <= 1'b0;
        end else if (cmd_stb) begin
            busy    <= 1'b1;
            cur_cmd <= cmd_new;
        end
    end

    always_comb begin
        phy_req  = busy;
        phy_wr   = cur_cmd.wr;
        phy_idx  = cur_cmd.idx;
        cap_en   = busy && phy_ack && !cur_cmd.wr;
        cap_byte = phy_rdata;
    end
endmodule

// File: rtl/phybr_top.sv
module phybr_top
    import phybr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hb_we,
    input  logic [HOST_AW-1:0] hb_addr,
    input  logic [HOST_DW-1:0] hb_wdata,
    output logic [HOST_DW-1:0] hb_rdata,
    output logic               phy_req,
    output logic               phy_wr,
    output logic [IDX_W-1:0]   phy_idx,
    output logic [BYTE_W-1:0]  phy_wdata,
    input  logic               phy_ack,
    input  logic [BYTE_W-1:0]  phy_rdata
);
    logic               busy;
    phy_cmd_t           cur_cmd;
    phy_cmd_t           cmd_new;
    logic               cmd_stb;
    logic               cap_en;
    logic [BYTE_W-1:0]  cap_byte;
    logic [HOST_DW-1:0] data_q;

    phybr_hostregs u_regs (
        .clk      (clk),
        .rst      (rst),
        .hb_we    (hb_we),
        .hb_addr  (hb_addr),
        .hb_wdata (hb_wdata),
        .hb_rdata (hb_rdata),
        .busy     (busy),
        .cur_cmd  (cur_cmd),
        .cap_en   (cap_en),
        .cap_byte (cap_byte),
        .cmd_stb  (cmd_stb),
        .cmd_new  (cmd_new),
        .data_q   (data_q)
    );

    phybr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_stb   (cmd_stb),
        .cmd_new   (cmd_new),
        .busy      (busy),
        .cur_cmd   (cur_cmd),
        .phy_req   (phy_req),
        .phy_wr    (phy_wr),
        .phy_idx   (phy_idx),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .cap_en    (cap_en),
        .cap_byte  (cap_byte)
    );

    assign phy_wdata = data_q[BYTE_W-1:0];
endmodule

// File: rtl/phybr_chk.sv
module phybr_chk
    import phybr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               hb_we,
    input logic [HOST_AW-1:0] hb_addr,
    input logic [HOST_DW-1:0] hb_wdata,
    input logic [HOST_DW-1:0] hb_rdata,
    input logic               phy_req,
    input logic               phy_wr,
    input logic [IDX_W-1:0]   phy_idx,
    input logic [BYTE_W-1:0]  phy_wdata,
    input logic               phy_ack,
    input logic [BYTE_W-1:0]  phy_rdata
);
    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (hb_we && hb_addr == CMD_OFS && !phy_req) |=> phy_req);

    // R5
    end_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_ack) |=> !phy_req);

    // R8
    req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_idx) && $stable(phy_wr) && $stable(phy_wdata)));

    // R6
    busy_cmd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_ack && hb_we && hb_addr == CMD_OFS) |=> ($stable(phy_idx) && $stable(phy_wr)));

    // R4
    read_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_ack && !phy_wr) |=>
            (hb_addr != DATA_OFS || hb_rdata == HOST_DW'($past(phy_rdata))));
endmodule

bind phybr_top phybr_chk u_chk (.*);

// File: tb/phybr_top_test.sv
module phybr_top_test;
    import phybr_pkg::*;

    localparam int LAT = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               hb_we = 1'b0;
    logic [HOST_AW-1:0] hb_addr = '0;
    logic [HOST_DW-1:0] hb_wdata = '0;
    logic [HOST_DW-1:0] hb_rdata;
    logic               phy_req, phy_wr, phy_ack;
    logic [IDX_W-1:0]   phy_idx;
    logic [BYTE_W-1:0]  phy_wdata, phy_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    phybr_top uut (
        .clk(clk), .rst(rst), .hb_we(hb_we), .hb_addr(hb_addr),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .phy_req(phy_req),
        .phy_wr(phy_wr), .phy_idx(phy_idx), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    phybr_phymem #(.LATENCY(LAT)) u_phy (
        .clk(clk), .rst(rst), .req(phy_req), .wr(phy_wr), .idx(phy_idx),
        .wdata(phy_wdata), .ack(phy_ack), .rdata(phy_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [HOST_AW-1:0] a, input logic [HOST_DW-1:0] d);
        @(negedge clk);
        hb_we = 1'b1; hb_addr = a; hb_wdata = d;
        @(negedge clk);
        hb_we = 1'b0;
    endtask

    task automatic host_read(input logic [HOST_AW-1:0] a, output logic [HOST_DW-1:0] v);
        hb_addr = a;
        #1;
        v = hb_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [HOST_DW-1:0] v;
        n = 0;
        for (int k = 0; k < 100; k++) begin
            host_read(CMD_OFS, v);
            if (!v[BUSY_BIT]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic phy_op(input logic wr, input logic [IDX_W-1:0] idx, output int n);
        host_write(CMD_OFS, HOST_DW'({wr, idx}));
        wait_idle(n);
    endtask

    function automatic logic [7:0] wpat(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [HOST_DW-1:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        host_read(CMD_OFS, v);  chk("R1 cmd", v, 0);
        host_read(DATA_OFS, v); chk("R1 data", v, 0);

        // R2 data register store
        host_write(DATA_OFS, 16'h1234);
        host_read(DATA_OFS, v); chk("R2 data", v, 16'h1234);
        host_write(DATA_OFS, 16'hC3A9);
        host_read(DATA_OFS, v); chk("R2 data2", v, 16'hC3A9);

        // R10 / R4 / R5: reset pattern sweep
        for (int i = 0; i < 256; i++) begin
            host_write(DATA_OFS, 16'hFFFF);
            phy_op(1'b0, 8'(i), n);
            chk("R5 busy cycles", n, LAT + 2);
            host_read(DATA_OFS, v);
            chk("R4 R10 read", v, {8'h00, 8'(i) ^ 8'hA5});
        end

        // R3 write sweep, R9 readback
        for (int i = 0; i < 256; i++) begin
            host_write(DATA_OFS, {8'h5A, wpat(i)});
            phy_op(1'b1, 8'(i), n);
            host_read(CMD_OFS, v);
            chk("R9 cmd readback", v, 16'h0100 | 16'(i));
        end
        for (int i = 0; i < 256; i++) begin
            phy_op(1'b0, 8'(i), n);
            host_read(DATA_OFS, v);
            chk("R3 write readback", v, {8'h00, wpat(i)});
        end

        // R6 command write while busy
        host_write(CMD_OFS, 16'h0005);
        host_write(DATA_OFS, 16'h0077);      // R7 also ignored here
        host_write(CMD_OFS, 16'h0106);
        wait_idle(n);
        host_read(CMD_OFS, v);  chk("R6 cmd kept", v, 16'h0005);
        host_read(DATA_OFS, v); chk("R6 read data", v, {8'h00, wpat(5)});
        phy_op(1'b0, 8'd6, n);
        host_read(DATA_OFS, v); chk("R6 no second access", v, {8'h00, wpat(6)});

        // R7 data write while busy
        host_write(DATA_OFS, 16'h003C);
        host_write(CMD_OFS, 16'h0109);
        host_write(DATA_OFS, 16'h00E1);
        wait_idle(n);
        host_read(DATA_OFS, v); chk("R7 data kept", v, 16'h003C);
        phy_op(1'b0, 8'd9, n);
        host_read(DATA_OFS, v); chk("R7 phy byte", v, 16'h003C);

        // R1 reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        host_read(CMD_OFS, v);  chk("R1 cmd after rst", v, 0);
        host_read(DATA_OFS, v); chk("R1 data after rst", v, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule